// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block turns one warp-wide memory instruction into the fewest aligned 128-byte bus transactions that can serve it. Each of the 32 lanes supplies a 4-byte access address and an active flag. Lanes whose addresses fall in the same aligned 128-byte segment share one transaction. How many transactions a request needs is only known at run time, so the request is replayed one segment per cycle until every active lane is covered.

A request is accepted only while the block is idle. On each replay step the block picks the lowest-numbered lane that is still pending. It clears the low seven bits of that lane's address to form the segment base. It gathers every pending lane in that segment into a lane mask. It then offers the base and the mask on a valid/ready port. When the last segment has been handed off, a one-cycle completion strobe rises. A counter then holds how many transactions the request used. A request with no active lanes completes at once and issues nothing.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `req_ready` is 1, and `txn_valid`, `done` and `txn_count` are 0.
- R2: Every offered `txn_base` has bits [6:0] equal to zero. Its upper bits equal the upper bits of the address of the lowest-numbered lane still pending, so transactions come out in order of their lowest served lane.
- R3: `txn_mask` bit i is 1 exactly when lane i is still pending and its address bits [31:7] equal `txn_base` bits [31:7].
- R4: Each active lane appears in exactly one transaction mask of its request. An inactive lane appears in none.
- R5: The number of transactions equals the number of distinct 128-byte segments touched by active lanes. 32 contiguous word addresses starting on a 128-byte boundary take exactly one transaction.
- R6: While `txn_valid` is 1 and `txn_ready` is 0, `txn_valid`, `txn_base` and `txn_mask` hold their values into the next cycle.
- R7: `done` is 1 for exactly one cycle: the cycle after the clock edge on which the final transaction handshakes. It is never 1 before that.
- R8: A request accepted with `req_active` all zero issues no transaction. It raises `done` in the cycle after acceptance, with `txn_count` equal to 0.
- R9: `req_ready` is 1 only while no transaction is outstanding. A request presented while busy is ignored, and the transaction stream in progress continues unchanged.
- R10: `txn_count` equals the number of transactions issued for the most recent request. It keeps that value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A warp request is presented |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_active | input | 32 | Per-lane participation flags |
| req_addr | input | 1024 | Lane byte addresses, lane i in bits [32*i+31:32*i] |
| txn_valid | output | 1 | A segment transaction is offered |
| txn_ready | input | 1 | Downstream takes the offered transaction |
| txn_base | output | 32 | Segment base address, 128-byte aligned |
| txn_mask | output | 32 | Lanes served by the offered transaction |
| done | output | 1 | One-cycle strobe: request fully served |
| txn_count | output | 6 | Transactions issued for the last request |

## Verification
A corrupted pending set shows at the ports within one transaction. A lane dropped too early never appears in any mask. A lane cleared too late reappears in a later mask, or keeps `done` from rising when the mask sequence runs out. A wrong choice of leading lane shows at once as a base out of order. A wrong tag compare shows at once as a mask that differs from the lanes sharing the segment. Stalls from the downstream port are inserted at random, so any state that moves without a handshake shows up as a base or mask that changes while held, or as a skipped segment.

// File: rtl/coal_pkg.sv
// Shared definitions for the warp coalescer.
// Assumes: nothing beyond a two-state controller.
package coal_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } coal_state_e;
endpackage

// File: rtl/coal_lead_pick.sv
// Finds the lowest-numbered set bit of the pending-lane vector.
// Assumes: LANES >= 2; lead_idx is meaningless when any_pend is 0.
module coal_lead_pick #(
    parameter int LANES = 32,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] pend,
    output logic [IDX_W-1:0] lead_idx,
    output logic             any_pend
);
    // Priority scan from the top down, so the lowest set lane wins last.
    always_comb begin
        lead_idx = '0;
        any_pend = 1'b0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                lead_idx = IDX_W'(i);
                any_pend = 1'b1;
            end
        end
    end
endmodule

// File: rtl/coal_seg_match.sv
// Marks every pending lane whose address lies in the segment named by tag.
// Assumes: a segment is 2**SEG_BITS bytes, aligned to its own size.
module coal_seg_match #(
    parameter int LANES    = 32,
    parameter int ADDR_W   = 32,
    parameter int SEG_BITS = 7,
    localparam int TAG_W   = ADDR_W - SEG_BITS
) (
    input  logic [LANES-1:0][ADDR_W-1:0] addr,
    input  logic [LANES-1:0]             pend,
    input  logic [TAG_W-1:0]             tag,
    output logic [LANES-1:0]             hit
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // One tag comparator per lane.
        assign hit[g] = pend[g] && (addr[g][ADDR_W-1:SEG_BITS] == tag);
    end
endmodule

// File: rtl/warp_coalescer.sv
// Groups the lane addresses of one warp request into aligned segment
// transactions, one per cycle, on a valid/ready port.
// Assumes: each lane access is one word that does not cross a segment;
// a request is accepted only while idle; the offered transaction depends
// on registered state only, so it stays put under back-pressure.
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES     = 32,
    parameter int ADDR_W    = 32,
    parameter int SEG_BYTES = 128,
    localparam int SEG_BITS = $clog2(SEG_BYTES),
    localparam int TAG_W    = ADDR_W - SEG_BITS,
    localparam int IDX_W    = $clog2(LANES),
    localparam int CNT_W    = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES-1:0]        req_active,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_base,
    output logic [LANES-1:0]        txn_mask,
    output logic                    done,
    output logic [CNT_W-1:0]        txn_count
);
    coal_state_e                 state_q;
    logic [LANES-1:0]            pend_q;
    logic [LANES-1:0][ADDR_W-1:0] addr_q;
    logic [LANES-1:0][ADDR_W-1:0] req_addr_v;
    logic [CNT_W-1:0]            count_q;
    logic                        done_q;

    logic [IDX_W-1:0]            lead_idx;
    logic                        any_pend;
    logic [TAG_W-1:0]            lead_tag;
    logic [LANES-1:0]            seg_hit;
    logic [LANES-1:0]            pend_nxt;
    logic                        accept;
    logic                        fire;

    // View the flat address bus as one word per lane.
    assign req_addr_v = req_addr;

    coal_lead_pick #(.LANES(LANES)) u_pick (
        .pend     (pend_q),
        .lead_idx (lead_idx),
        .any_pend (any_pend)
    );

    // Segment tag of the leading pending lane.
    assign lead_tag = addr_q[lead_idx][ADDR_W-1:SEG_BITS];

    coal_seg_match #(
        .LANES    (LANES),
        .ADDR_W   (ADDR_W),
        .SEG_BITS (SEG_BITS)
    ) u_match (
        .addr (addr_q),
        .pend (pend_q),
        .tag  (lead_tag),
        .hit  (seg_hit)
    );

    // Handshake and next pending set.
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign txn_valid = (state_q == ST_BUSY) && any_pend;
    assign fire      = txn_valid && txn_ready;
    assign pend_nxt  = pend_q & ~seg_hit;

    // Transaction outputs.
    assign txn_base  = {lead_tag, {SEG_BITS{1'b0}}};
    assign txn_mask  = seg_hit;
    assign done      = done_q;
    assign txn_count = count_q;

    // Controller: capture a request, retire one segment per handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            addr_q  <= '0;
            count_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                addr_q  <= req_addr_v;
                pend_q  <= req_active;
                count_q <= '0;
                if (req_active == '0) begin
                    done_q <= 1'b1;
                end else begin
                    state_q <= ST_BUSY;
                end
            end else if (fire) begin
                pend_q  <= pend_nxt;
                count_q <= count_q + CNT_W'(1);
                if (pend_nxt == '0) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/coal_checker.sv
// Port-level protocol checks for warp_coalescer, bound to every instance.
// Assumes: the same parameters as the bound instance.
module coal_checker #(
    parameter int LANES     = 32,
    parameter int ADDR_W    = 32,
    parameter int SEG_BYTES = 128,
    localparam int SEG_BITS = $clog2(SEG_BYTES),
    localparam int CNT_W    = $clog2(LANES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LANES-1:0]  req_active,
    input logic              txn_valid,
    input logic              txn_ready,
    input logic [ADDR_W-1:0] txn_base,
    input logic [LANES-1:0]  txn_mask,
    input logic              done,
    input logic [CNT_W-1:0]  txn_count
);
    logic [LANES-1:0] act_q;
    logic [LANES-1:0] served_q;
    logic [CNT_W-1:0] fires_q;

    // Track the active lanes, the lanes served so far and the handshakes seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= '0;
            served_q <= '0;
            fires_q  <= '0;
        end else if (req_valid && req_ready) begin
            act_q    <= req_active;
            served_q <= '0;
            fires_q  <= '0;
        end else if (txn_valid && txn_ready) begin
            served_q <= served_q | txn_mask;
            fires_q  <= fires_q + CNT_W'(1);
        end
    end

    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> txn_base[SEG_BITS-1:0] == '0); // R2
    AST_MASK_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_mask != '0) && ((txn_mask & served_q) == '0)); // R4
    AST_MASK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_mask & ~act_q) == '0); // R4
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> txn_valid && $stable(txn_base) && $stable(txn_mask)); // R6
    AST_DONE_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> served_q == act_q); // R7
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> !req_ready); // R9
    AST_EMPTY_NO_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_active == '0) |=> done && !txn_valid); // R8
    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> txn_count == fires_q); // R10
endmodule

bind warp_coalescer coal_checker #(
    .LANES     (LANES),
    .ADDR_W    (ADDR_W),
    .SEG_BYTES (SEG_BYTES)
) u_chk (.*);

// File: tb/warp_coalescer_test.sv
// Sweeps many lane-address patterns through warp_coalescer under random
// back-pressure and compares each transaction with an arithmetic model.
module warp_coalescer_test;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 32;
    localparam int ADDR_W     = 32;
    localparam int CNT_W      = 6;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_valid = 1'b0;
    logic                    req_ready;
    logic [LANES-1:0]        req_active = '0;
    logic [LANES*ADDR_W-1:0] req_addr = '0;
    logic                    txn_valid;
    logic                    txn_ready = 1'b0;
    logic [ADDR_W-1:0]       txn_base;
    logic [LANES-1:0]        txn_mask;
    logic                    done;
    logic [CNT_W-1:0]        txn_count;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    int prev_n = 0;

    logic [ADDR_W-1:0] a [LANES];
    logic [LANES-1:0]  act;
    logic [ADDR_W-1:0] exp_base [LANES];
    logic [LANES-1:0]  exp_mask [LANES];
    int exp_n;
    int exp_distinct;

    warp_coalescer uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_active(req_active), .req_addr(req_addr), .txn_valid(txn_valid),
        .txn_ready(txn_ready), .txn_base(txn_base), .txn_mask(txn_mask),
        .done(done), .txn_count(txn_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Watchdog: an overlong run is a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] actual, input logic [63:0] expected);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
        end
    endtask

    // Expected transaction list: lowest pending lane leads, its segment is served.
    task automatic build_expect();
        logic [LANES-1:0] pend = act;
        exp_n = 0;
        while (pend != '0) begin
            int lead = 0;
            logic [ADDR_W-8:0] tag;
            logic [LANES-1:0] m = '0;
            for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
            tag = a[lead][ADDR_W-1:7];
            for (int i = 0; i < LANES; i++)
                if (pend[i] && a[i][ADDR_W-1:7] == tag) m[i] = 1'b1;
            exp_base[exp_n] = {tag, 7'b0};
            exp_mask[exp_n] = m;
            exp_n++;
            pend &= ~m;
        end
        // Independent count of distinct segments among active lanes (R5).
        exp_distinct = 0;
        for (int i = 0; i < LANES; i++) begin
            bit first = act[i];
            for (int j = 0; j < i; j++)
                if (act[i] && act[j] && a[j][ADDR_W-1:7] == a[i][ADDR_W-1:7]) first = 0;
            if (first) exp_distinct++;
        end
    endtask

    task automatic run_req(input int stall_pct, input bit poke_busy);
        int idx = 0;
        int cyc = 0;
        bit held = 0;
        logic [ADDR_W-1:0] h_base;
        logic [LANES-1:0]  h_mask;
        build_expect();
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready while idle", 64'(req_ready), 64'd1);
        chk(int'(txn_count) == prev_n, "R10", "count held", 64'(txn_count), 64'(prev_n));
        req_valid = 1'b1;
        req_active = act;
        for (int i = 0; i < LANES; i++) req_addr[i*ADDR_W +: ADDR_W] = a[i];
        @(negedge clk);
        req_valid = 1'b0;
        forever begin
            req_valid = 1'b0;
            if (done) begin
                chk(idx == exp_n, "R7", "done after last handshake", 64'(idx), 64'(exp_n));
                chk(int'(txn_count) == exp_n, "R10", "txn_count", 64'(txn_count), 64'(exp_n));
                chk(exp_n == exp_distinct, "R5", "segment count", 64'(exp_n), 64'(exp_distinct));
                break;
            end
            if (txn_valid) begin
                chk(req_ready == 1'b0, "R9", "ready while busy", 64'(req_ready), 64'd0);
                if (idx >= exp_n) begin
                    chk(1'b0, "R4", "extra transaction", 64'(idx), 64'(exp_n));
                    break;
                end
                if (held) begin
                    chk(txn_base == h_base && txn_mask == h_mask, "R6", "stall hold",
                        64'(txn_mask), 64'(h_mask));
                end
                chk(txn_base == exp_base[idx], "R2", "txn_base", 64'(txn_base), 64'(exp_base[idx]));
                chk(txn_mask == exp_mask[idx], "R3 R4", "txn_mask", 64'(txn_mask), 64'(exp_mask[idx]));
                txn_ready = (int'($urandom % 100) >= stall_pct);
                if (txn_ready) begin
                    idx++;
                    held = 0;
                end else begin
                    held = 1;
                    h_base = txn_base;
                    h_mask = txn_mask;
                end
                if (poke_busy && cyc == 1) begin
                    req_valid = 1'b1;
                    req_active = ~act;
                    req_addr = {LANES{32'h5A5A_0F00}};
                end
            end else begin
                txn_ready = 1'b0;
                if (held) chk(1'b0, "R6", "valid dropped while held", 64'd0, 64'd1);
            end
            @(negedge clk);
            cyc++;
            if (cyc > 400) begin
                chk(1'b0, "R7", "done never rose", 64'(idx), 64'(exp_n));
                break;
            end
        end
        txn_ready = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R7", "done is one cycle", 64'(done), 64'd0);
        chk(txn_valid == 1'b0, "R8", "idle after done", 64'(txn_valid), 64'd0);
        prev_n = exp_n;
    endtask

    initial begin
        for (int i = 0; i < LANES; i++) a[i] = '0;
        act = '0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
        chk(txn_valid == 1'b0, "R1", "reset valid", 64'(txn_valid), 64'd0);
        chk(done == 1'b0, "R1", "reset done", 64'(done), 64'd0);
        chk(txn_count == '0, "R1", "reset count", 64'(txn_count), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && txn_valid == 1'b0, "R1", "after reset",
            64'({req_ready, txn_valid}), 64'd2);

        // R5: contiguous aligned words make one transaction.
        for (int i = 0; i < LANES; i++) a[i] = 32'h0000_1000 + 32'(4 * i);
        act = '1;
        run_req(0, 0);
        // Contiguous but offset by half a segment: two transactions.
        for (int i = 0; i < LANES; i++) a[i] = 32'h0000_2040 + 32'(4 * i);
        run_req(40, 1);
        // One segment per lane, with heavy back-pressure.
        for (int i = 0; i < LANES; i++) a[i] = 32'h0001_0000 + 32'(128 * i);
        run_req(60, 0);
        // All lanes on one word.
        for (int i = 0; i < LANES; i++) a[i] = 32'hFFFF_FF7C;
        run_req(20, 0);
        // Descending segments with a sparse active set.
        for (int i = 0; i < LANES; i++) a[i] = 32'h0800_0000 + 32'(128 * ((LANES - 1 - i) / 3));
        act = 32'hA5C3_0F18;
        run_req(30, 1);
        // R8: empty request, twice in a row.
        act = '0;
        run_req(0, 0);
        run_req(0, 0);
        // Single top lane.
        act = 32'h8000_0000;
        run_req(50, 0);

        // Random sweep over small segment pools.
        for (int t = 0; t < 400; t++) begin
            int pool = 1 + int'($urandom % 8);
            logic [ADDR_W-1:0] segs [8];
            for (int s = 0; s < 8; s++) segs[s] = {$urandom, 7'b0} & 32'h0000_FF80;
            for (int i = 0; i < LANES; i++)
                a[i] = segs[$urandom % pool] + 32'(4 * ($urandom % 32));
            case (t % 4)
                0: act = '1;
                1: act = $urandom;
                2: act = $urandom & $urandom;
                default: act = (t % 16 == 3) ? '0 : 32'(1) << ($urandom % 32);
            endcase
            run_req((t % 3) * 35, (t % 5) == 0);
        end
        summary();
    end
endmodule